// File: doc/BRIEF.md
# Multiplier cycle cost estimator

This unit predicts how many internal cycles a 16x16 shift-add multiply will take. The cost depends on the bit pattern of the multiplier operand. A scheduler or timing model presents the operand together with a signedness select and a valid strobe. One clock later the unit returns the predicted cycle count and pulses a valid flag. The unit only estimates timing; it does not perform the multiplication.

Every multiply costs a fixed base of 17 cycles plus a term that depends on the operand:

- **Unsigned multiply:** the term is the number of ones in the low 16 bits of the operand.
- **Signed multiply:** the term counts the places where adjacent bits differ, as in Booth recoding. A zero bit is assumed below bit 0, and the check stops at bit 15.

Top module: `mul_cost_est`

## Requirements
- R1: While reset is high, the next clock edge clears `cost_vld` to 0 and `cost_cycles` to 0.
- R2: `cost_vld` is 1 in the cycle after a cycle in which `op_vld` was sampled high, and 0 after a cycle in which it was sampled low.
- R3: When `op_signed` is 0, the count is 17 plus the number of ones in `op_mult[15:0]`.
- R4: When `op_signed` is 1, the count is 17 plus the number of ones in `(m ^ (m << 1)) & 16'hFFFF`, where `m = op_mult[15:0]`. Examples: m=0 gives 17, m=16'hFFFF gives 18, m=16'h0001 gives 19.
- R5: Bits of `op_mult` above bit 15 have no effect on the count.
- R6: Every valid count lies in the range 17 to 33. The value 33 is reached by unsigned 16'hFFFF and by signed 16'h5555.
- R7: `cost_cycles` keeps its last value in every cycle that follows one with `op_vld` low.
- R8: Strobes on back-to-back cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_vld | input | 1 | Operand valid strobe |
| op_signed | input | 1 | 1 = signed (transition count), 0 = unsigned (ones count) |
| op_mult | input | IN_W (32) | Multiplier operand; only bits 15:0 are used |
| cost_vld | output | 1 | One-cycle pulse marking a new count |
| cost_cycles | output | COUNT_W (6) | Registered cycle count |

## Verification
The only state in the block is its output register. A wrong pattern vector or a wrong ones-count therefore shows up as a wrong `cost_cycles` value in the very cycle after the strobe. A stuck or stretched valid flag shows up on `cost_vld` in that same cycle. A reference model compares both outputs on every clock, so any fault appears within one cycle of the strobe that exposes it. The directed operands (all ones, alternating bits, zero, and junk in the upper bits) pick out faults in the signed shift path and in the masking of the upper bits.

// File: rtl/mul_cost_pkg.sv
package mul_cost_pkg;
  localparam int unsigned OPND_W_DEF = 16;
  localparam int unsigned BASE_DEF   = 17;

  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } cost_mode_e;
endpackage

// File: rtl/mul_cost_pattern.sv
// Builds the vector whose ones are counted: the operand itself (unsigned),
// or the adjacent-bit difference vector with zero below bit 0 (signed).
module mul_cost_pattern
  import mul_cost_pkg::*;
#(
  parameter int unsigned W = OPND_W_DEF
) (
  input  logic [W-1:0] opnd,
  input  cost_mode_e   mode,
  output logic [W-1:0] pattern
);
  logic [W-1:0] below;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      if (gi == 0) begin : g_lsb
        assign below[gi] = 1'b0;
      end else begin : g_upper
        assign below[gi] = opnd[gi-1];
      end
      assign pattern[gi] = opnd[gi] ^ ((mode == MODE_SIGNED) & below[gi]);
    end
  endgenerate
endmodule

// File: rtl/mul_cost_popcnt.sv
module mul_cost_popcnt #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/mul_cost_est.sv
module mul_cost_est
  import mul_cost_pkg::*;
#(
  parameter int unsigned IN_W      = 32,
  parameter int unsigned OPND_W    = OPND_W_DEF,
  parameter int unsigned BASE_COST = BASE_DEF,
  localparam int unsigned CW       = $clog2(OPND_W + 1),
  localparam int unsigned COUNT_W  = $clog2(BASE_COST + OPND_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_vld,
  input  logic               op_signed,
  input  logic [IN_W-1:0]    op_mult,
  output logic               cost_vld,
  output logic [COUNT_W-1:0] cost_cycles
);
  logic [OPND_W-1:0] opnd_lo;
  logic [OPND_W-1:0] pattern;
  logic [CW-1:0]     ones;
  cost_mode_e        mode;

  assign opnd_lo = op_mult[OPND_W-1:0];
  assign mode    = op_signed ? MODE_SIGNED : MODE_UNSIGNED;

  mul_cost_pattern #(.W(OPND_W)) u_pat (
    .opnd    (opnd_lo),
    .mode    (mode),
    .pattern (pattern)
  );

  mul_cost_popcnt #(.W(OPND_W)) u_cnt (
    .vec  (pattern),
    .ones (ones)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cost_vld    <= 1'b0;
      cost_cycles <= '0;
    end else begin
      cost_vld <= op_vld;
      if (op_vld) begin
        cost_cycles <= COUNT_W'(BASE_COST) + COUNT_W'(ones);
      end
    end
  end

  // R1: reset clears outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!cost_vld && cost_cycles == '0));

  // R2: valid follows strobe by one cycle
  p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
    op_vld |=> cost_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> !cost_vld);

  // R6: count range
  p_count_range_r6: assert property (@(posedge clk) disable iff (rst)
    cost_vld |-> (cost_cycles >= COUNT_W'(BASE_COST) &&
                  cost_cycles <= COUNT_W'(BASE_COST + OPND_W)));

  // R7: count holds without a strobe
  p_count_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !op_vld |=> $stable(cost_cycles));
endmodule

// File: tb/sim_mul_cost_est.sv
module sim_mul_cost_est;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_vld = 1'b0;
  logic        op_signed = 1'b0;
  logic [31:0] op_mult = '0;
  logic        cost_vld;
  logic [5:0]  cost_cycles;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_vld = 0;
  int m_cyc = 0;

  always #4 clk = ~clk;

  mul_cost_est u0 (
    .clk(clk), .rst(rst), .op_vld(op_vld), .op_signed(op_signed),
    .op_mult(op_mult), .cost_vld(cost_vld), .cost_cycles(cost_cycles)
  );

  function automatic int ref_cost(bit sgn, logic [31:0] v);
    int n = 0;
    int prev = 0;
    for (int i = 0; i < 16; i++) begin
      int b = int'(v[i]);
      if (sgn) begin
        if (b != prev) n++;
        prev = b;
      end else begin
        n += b;
      end
    end
    return 17 + n;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on each edge
  always @(posedge clk) begin
    if (rst) begin
      m_vld = 0;
      m_cyc = 0;
    end else begin
      m_vld = op_vld;
      if (op_vld) m_cyc = ref_cost(op_signed, op_mult);
    end
  end

  // per-cycle comparison (R2, R3/R4, R7)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cost_vld == m_vld, "R2 vld", int'(cost_vld), int'(m_vld));
      check(int'(cost_cycles) == m_cyc, "R3/R4/R7 count", int'(cost_cycles), m_cyc);
    end
  end

  task automatic apply(bit sgn, logic [31:0] v);
    op_vld = 1'b1; op_signed = sgn; op_mult = v;
    @(negedge clk);
    op_vld = 1'b0;
  endtask

  task automatic run_all();
    @(negedge clk); @(negedge clk);
    check(cost_vld == 1'b0 && cost_cycles == 6'd0, "R1 reset", int'(cost_cycles), 0);
    rst = 1'b0;
    @(negedge clk);
    apply(0, 32'h0000_FFFF);
    check(cost_cycles == 6'd33 && cost_vld, "R6 unsigned max", int'(cost_cycles), 33);
    apply(1, 32'h0000_5555);
    check(cost_cycles == 6'd33, "R6 signed max", int'(cost_cycles), 33);
    apply(1, 32'h0000_0000);
    check(cost_cycles == 6'd17, "R4 signed zero", int'(cost_cycles), 17);
    apply(1, 32'h0000_FFFF);
    check(cost_cycles == 6'd18, "R4 signed all ones", int'(cost_cycles), 18);
    apply(1, 32'h0000_0001);
    check(cost_cycles == 6'd19, "R4 signed lsb", int'(cost_cycles), 19);
    apply(0, 32'h0000_0101);
    check(cost_cycles == 6'd19, "R3 unsigned two bits", int'(cost_cycles), 19);
    apply(0, 32'hABCD_0000);
    check(cost_cycles == 6'd17, "R5 upper ignored unsigned", int'(cost_cycles), 17);
    apply(1, 32'hFFFF_8000);
    check(cost_cycles == 6'd18, "R5 upper ignored signed", int'(cost_cycles), 18);
    @(negedge clk);
    check(cost_vld == 1'b0, "R2 single pulse", int'(cost_vld), 0);
    check(cost_cycles == 6'd18, "R7 hold", int'(cost_cycles), 18);
    // R8: back-to-back stream
    op_vld = 1'b1;
    for (int k = 0; k < 200; k++) begin
      op_signed = $urandom_range(0, 1);
      op_mult = $urandom;
      @(negedge clk);
    end
    op_vld = 1'b0;
    // sparse stream
    for (int k = 0; k < 200; k++) begin
      op_vld = $urandom_range(0, 1);
      op_signed = $urandom_range(0, 1);
      op_mult = $urandom;
      @(negedge clk);
    end
    op_vld = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(cost_vld == 1'b0 && cost_cycles == 6'd0, "R1 reset again", int'(cost_cycles), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule